// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a reference clock from one of up to sixteen candidate clocks. The candidates are slow clocks, oversampled by a faster system clock `clk`. The block detects each rising edge of the chosen candidate and counts those edges to build the output. The period of the output is `2*(N + M/512)` candidate periods. `N` is a 15-bit integer divisor and `M` is a 9-bit fractional trim. When `N` is zero the divider is bypassed: the output follows the chosen candidate directly, and `M` has no effect.

Software uses a small two-word register port. Word 0 is the control word and word 1 holds the trim. The divisor and the trim can be written at any time. The running divider only adopts new values after software sets the self-clearing switch bit. The new values are then taken at the end of an output half-period, so a ratio change never cuts a half-period short. A status bit reports when the block is busy. While it is busy, a new source selection is refused.

Top module: `refclk_frac_div`

## Requirements
- R1: After a synchronous active-low reset, both register words read 0 and `ref_out` is low.
- R2: Word 0 holds the source select in bits 3:0, the read-only busy status in bit 8, the switch request in bit 9, the output enable in bit 12, the run bit in bit 15 and the divisor N in bits 30:16. Word 1 holds the trim M in bits 31:23. All other bits read 0.
- R3: With N>0 and M=0, each output period is exactly 2N periods of the chosen candidate.
- R4: With N>0 and M>0, each half-period lasts N or N+1 candidate periods. A 9-bit accumulator adds M at every half-period boundary. A carry out of this accumulator lengthens the next half-period by one, so the average period is 2*(N+M/512) candidate periods.
- R5: With N=0 and the run and output-enable bits set, `ref_out` follows the chosen candidate, delayed by two `clk` cycles.
- R6: The busy bit equals (run OR switch pending). A control write while busy leaves the select field unchanged.
- R7: A pending switch is taken in one of three cases: on the next cycle when the run bit is 0 or the divider is bypassed, and otherwise at the end of the current output half-period. The switch bit then reads 0.
- R8: Writing N or M without a switch request does not change the running output ratio.
- R9: `ref_out` is low one cycle after the run bit or the output-enable bit is 0. After starting, the divided output begins low.
- R10: The divider counts rising edges of the selected candidate only. Its output changes only one cycle after such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the candidates |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | NSRC | Candidate clock levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write word: 0 control, 1 trim |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read word select |
| rd_data | output | 32 | Read data (combinational) |
| ref_out | output | 1 | Registered reference clock output |

## Verification
The hardest case to reach is a switch request that arrives while the divider runs. It must wait for the end of a half-period, while fresh divisor writes without the switch bit keep changing the stored values. The stimulus first writes a new divisor without a request and measures an unchanged period. It then requests the switch and measures the new period once it settles. For the fractional modes, the stimulus chooses trims of 256 and 128. The carry pattern then repeats every two and every four half-periods, so each measured window has an exact expected length. A behavioural model compares the output and the read data on every clock.

// File: rtl/rfd_pkg.sv
// Shared field positions of the register words of the reference divider.
// Assumes a 32-bit register port; positions are fixed by the register layout.
package rfd_pkg;
    localparam int DATA_W   = 32;
    localparam int SEL_LSB  = 0;
    localparam int BUSY_BIT = 8;
    localparam int SW_BIT   = 9;
    localparam int OE_BIT   = 12;
    localparam int RUN_BIT  = 15;
    localparam int DIV_LSB  = 16;
    localparam int TRIM_LSB = 23;
endpackage

// File: rtl/rfd_regs.sv
// Register word storage, switch-request flag and read mux.
// Assumes SELW<=4, DIVW<=15, TRIMW<=9 so the fields fit the layout.
module rfd_regs
    import rfd_pkg::*;
#(
    parameter int SELW  = 4,
    parameter int DIVW  = 15,
    parameter int TRIMW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    input  logic              accept,
    output logic [SELW-1:0]   sel_q,
    output logic              on_q,
    output logic              oe_q,
    output logic [DIVW-1:0]   div_q,
    output logic [TRIMW-1:0]  trim_q,
    output logic              sw_pend,
    output logic              active,
    output logic [DATA_W-1:0] rd_data
);
    logic ctl_wr;
    logic unused_wr;

    assign ctl_wr    = wr_en && !wr_addr;
    assign active    = on_q | sw_pend;
    assign unused_wr = ^wr_data;

    // Capture register writes; select is refused while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            on_q    <= 1'b0;
            oe_q    <= 1'b0;
            div_q   <= '0;
            trim_q  <= '0;
            sw_pend <= 1'b0;
        end else begin
            if (ctl_wr) begin
                if (!active) sel_q <= wr_data[SEL_LSB +: SELW];
                oe_q  <= wr_data[OE_BIT];
                on_q  <= wr_data[RUN_BIT];
                div_q <= wr_data[DIV_LSB +: DIVW];
            end
            if (wr_en && wr_addr) trim_q <= wr_data[TRIM_LSB +: TRIMW];
            if (ctl_wr && wr_data[SW_BIT]) sw_pend <= 1'b1;
            else if (accept)               sw_pend <= 1'b0;
        end
    end

    // Assemble the addressed read word.
    always_comb begin
        rd_data = '0;
        if (!rd_addr) begin
            rd_data[SEL_LSB +: SELW] = sel_q;
            rd_data[BUSY_BIT]        = active;
            rd_data[SW_BIT]          = sw_pend;
            rd_data[OE_BIT]          = oe_q;
            rd_data[RUN_BIT]         = on_q;
            rd_data[DIV_LSB +: DIVW] = div_q;
        end else begin
            rd_data[TRIM_LSB +: TRIMW] = trim_q;
        end
    end
endmodule

// File: rtl/rfd_src_pick.sv
// Selects one oversampled candidate clock and flags its rising edges.
// Assumes candidates are slower than half the system clock rate.
module rfd_src_pick #(
    parameter int NSRC = 16,
    parameter int SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic [SELW-1:0] sel,
    output logic            lvl,
    output logic            src_edge
);
    logic lvl_d;

    // Sample the chosen level and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl   <= 1'b0;
            lvl_d <= 1'b0;
        end else begin
            lvl   <= src_clk[sel];
            lvl_d <= lvl;
        end
    end

    assign src_edge = lvl & ~lvl_d;
endmodule

// File: rtl/rfd_engine.sv
// Divide engine: half-period counter, fractional accumulator, switch accept.
// Assumes src_edge pulses for one cycle per candidate rising edge.
module rfd_engine #(
    parameter int DIVW  = 15,
    parameter int TRIMW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic             oe,
    input  logic             lvl,
    input  logic             src_edge,
    input  logic [DIVW-1:0]  div_r,
    input  logic [TRIMW-1:0] trim_r,
    input  logic             sw_pend,
    output logic             accept,
    output logic [DIVW-1:0]  div_a,
    output logic [TRIMW-1:0] trim_a,
    output logic             tog,
    output logic             ref_out
);
    localparam int CNTW = DIVW + 1;

    logic [CNTW-1:0]  cnt, cnt_nxt, len;
    logic [TRIMW-1:0] acc;
    logic [TRIMW:0]   sum;
    logic             extra, byp, hit;

    assign byp     = (div_a == '0);
    assign len     = {1'b0, div_a} + {{DIVW{1'b0}}, extra};
    assign cnt_nxt = cnt + 1'b1;
    assign sum     = {1'b0, acc} + {1'b0, trim_a};
    assign hit     = on && !byp && src_edge && (cnt_nxt == len);
    assign accept  = sw_pend && (!on || byp || hit);

    // Count candidate edges, toggle at half-period ends, load new ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a   <= '0;
            trim_a  <= '0;
            cnt     <= '0;
            acc     <= '0;
            extra   <= 1'b0;
            tog     <= 1'b0;
            ref_out <= 1'b0;
        end else begin
            ref_out <= (on && oe) ? (byp ? lvl : tog) : 1'b0;
            if (!on) begin
                tog   <= 1'b0;
                cnt   <= '0;
                acc   <= '0;
                extra <= 1'b0;
            end else if (byp) begin
                tog <= 1'b0;
                cnt <= '0;
            end else if (src_edge) begin
                if (hit) begin
                    tog   <= ~tog;
                    cnt   <= '0;
                    acc   <= sum[TRIMW-1:0];
                    extra <= sum[TRIMW];
                end else begin
                    cnt <= cnt_nxt;
                end
            end
            if (accept) begin
                div_a  <= div_r;
                trim_a <= trim_r;
                cnt    <= '0;
                acc    <= '0;
                extra  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/refclk_frac_div.sv
// Top of the fractional reference clock divider.
// Assumes all candidates are oversampled by clk; NSRC is at most 16.
module refclk_frac_div
    import rfd_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int DIVW  = 15,
    parameter int TRIMW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_clk,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ref_out
);
    localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [SELW-1:0]  sel_q;
    logic             on_q, oe_q, sw_pend, active, accept;
    logic [DIVW-1:0]  div_q, div_a;
    logic [TRIMW-1:0] trim_q, trim_a;
    logic             lvl, src_edge, tog;

    rfd_regs #(.SELW(SELW), .DIVW(DIVW), .TRIMW(TRIMW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .accept(accept),
        .sel_q(sel_q), .on_q(on_q), .oe_q(oe_q), .div_q(div_q),
        .trim_q(trim_q), .sw_pend(sw_pend), .active(active), .rd_data(rd_data)
    );

    rfd_src_pick #(.NSRC(NSRC), .SELW(SELW)) u_pick (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .sel(sel_q),
        .lvl(lvl), .src_edge(src_edge)
    );

    rfd_engine #(.DIVW(DIVW), .TRIMW(TRIMW)) u_eng (
        .clk(clk), .rst_n(rst_n), .on(on_q), .oe(oe_q), .lvl(lvl),
        .src_edge(src_edge), .div_r(div_q), .trim_r(trim_q),
        .sw_pend(sw_pend), .accept(accept), .div_a(div_a),
        .trim_a(trim_a), .tog(tog), .ref_out(ref_out)
    );
endmodule

// File: rtl/refclk_frac_div_chk.sv
// Property checker for refclk_frac_div, attached through bind.
module refclk_frac_div_chk #(
    parameter int SELW  = 4,
    parameter int DIVW  = 15,
    parameter int TRIMW = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr,
    input logic             on_q,
    input logic             oe_q,
    input logic [SELW-1:0]  sel_q,
    input logic             sw_pend,
    input logic             active,
    input logic [DIVW-1:0]  div_a,
    input logic [TRIMW-1:0] trim_a,
    input logic             tog,
    input logic             src_edge,
    input logic             ref_out
);
    assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |=> !ref_out);
    assert_oe_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |=> !ref_out);
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(sel_q));
    assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_pend |=> ($stable(div_a) && $stable(trim_a)));
    assert_idle_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pend && !on_q && !sw_wr) |=> !sw_pend);
    assert_edge_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tog) |-> $past(src_edge));
endmodule

bind refclk_frac_div refclk_frac_div_chk #(.SELW(SELW), .DIVW(DIVW), .TRIMW(TRIMW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sw_wr(wr_en && !wr_addr && wr_data[rfd_pkg::SW_BIT]),
    .on_q(on_q), .oe_q(oe_q), .sel_q(sel_q), .sw_pend(sw_pend),
    .active(active), .div_a(div_a), .trim_a(trim_a), .tog(tog),
    .src_edge(src_edge), .ref_out(ref_out)
);

// File: tb/sim_refclk_frac_div.sv
module sim_refclk_frac_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src = '0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ref_out;

    int checks = 0, failures = 0, cyc = 0, wd = 0;
    string cur_req = "R1";
    bit done = 0;

    // model state
    int m_sel, m_on, m_oe, m_div, m_trim, m_pend;
    int a_div, a_trim, m_cnt, m_acc, m_extra, m_tog, l1, l2, m_out;

    refclk_frac_div u0 (.clk(clk), .rst_n(rst_n), .src_clk(src), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ref_out(ref_out));

    always #10 clk = ~clk;

    // candidate k has a half period of k+2 system cycles
    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < 16; k++) src[k] <= ((cyc / (k + 2)) % 2) == 1;
    end

    function automatic logic [31:0] mk(int sel, int sw, int oe, int on, int dv);
        return (32'(dv) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel);
    endfunction

    function automatic logic [31:0] m_rd(logic a);
        if (a) return 32'(m_trim) << 23;
        return mk(m_sel, m_pend, m_oe, m_on, m_div) | (32'(m_on | m_pend) << 8);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        int edg, byp, hit, acc_ok, s;
        if (!rst_n) begin
            m_sel = 0; m_on = 0; m_oe = 0; m_div = 0; m_trim = 0; m_pend = 0;
            a_div = 0; a_trim = 0; m_cnt = 0; m_acc = 0; m_extra = 0; m_tog = 0;
            l1 = 0; l2 = 0; m_out = 0;
            return;
        end
        edg = l1 && !l2;
        byp = (a_div == 0);
        hit = m_on && !byp && edg && (m_cnt + 1 == a_div + m_extra);
        acc_ok = m_pend && (!m_on || byp || hit);
        m_out = (m_on && m_oe) ? (byp ? l1 : m_tog) : 0;
        l2 = l1;
        l1 = src[m_sel];
        if (!m_on) begin m_tog = 0; m_cnt = 0; m_acc = 0; m_extra = 0; end
        else if (byp) begin m_tog = 0; m_cnt = 0; end
        else if (edg) begin
            if (hit) begin
                m_tog = 1 - m_tog; m_cnt = 0;
                s = m_acc + a_trim; m_extra = (s >= 512); m_acc = s % 512;
            end else m_cnt++;
        end
        if (acc_ok) begin a_div = m_div; a_trim = m_trim; m_cnt = 0; m_acc = 0; m_extra = 0; end
        if (wr_en && !wr_addr) begin
            if (!(m_on || m_pend)) m_sel = int'(wr_data[3:0]);
            m_oe = wr_data[12]; m_on = wr_data[15]; m_div = int'(wr_data[30:16]);
        end
        if (wr_en && wr_addr) m_trim = int'(wr_data[31:23]);
        if (wr_en && !wr_addr && wr_data[9]) m_pend = 1;
        else if (acc_ok) m_pend = 0;
    endtask

    // per-clock comparison against the model, plus watchdog
    always @(posedge clk) begin
        model_step();
        #2;
        if (!done) begin
            chk({cur_req, " ref_out"}, {31'b0, ref_out}, 32'(m_out));
            chk({cur_req, " rd_data"}, rd_data, m_rd(rd_addr));
            wd++;
            if (wd > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<150000", wd);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic wr(logic a, logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        @(negedge clk); rd_addr = a; #1 d = rd_data;
    endtask

    task automatic meas(int n, output int res);
        logic prev; int seen, t;
        prev = ref_out; seen = -1; t = 0; res = -1;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #3;
            if (seen >= 0) t++;
            if (ref_out && !prev) begin
                if (seen < 0) begin seen = 0; t = 0; end
                else begin seen++; if (seen == n) begin res = t; break; end end
            end
            prev = ref_out;
        end
    endtask

    initial begin
        logic [31:0] d; int p; int highs;
        idle(3);
        cur_req = "R1";
        rd(0, d); chk("R1 ctrl", d, 0);
        rd(1, d); chk("R1 trim", d, 0);
        chk("R1 ref_out", {31'b0, ref_out}, 0);
        @(negedge clk); rst_n = 1;
        idle(2);

        cur_req = "R3";
        wr(1, 0);
        wr(0, mk(0, 1, 1, 1, 2));
        idle(4);
        rd(0, d); chk("R2 ctrl layout", d, 32'h0002_9100);
        meas(1, p); meas(1, p); chk("R3 N=2 period", p, 16);

        cur_req = "R8";
        wr(0, mk(0, 0, 1, 1, 3));
        meas(1, p); chk("R8 no switch keeps ratio", p, 16);
        wr(0, mk(0, 1, 1, 1, 3));
        meas(1, p); meas(1, p); chk("R3 N=3 period", p, 24);
        rd(0, d); chk("R7 switch bit cleared", {31'b0, d[9]}, 0);

        cur_req = "R6";
        wr(0, mk(5, 0, 1, 1, 3));
        idle(2);
        rd(0, d); chk("R6 select ignored while busy", {28'b0, d[3:0]}, 0);

        cur_req = "R4";
        wr(1, 32'(256) << 23);
        rd(1, d); chk("R2 trim layout", d, 32'h8000_0000);
        wr(0, mk(0, 1, 1, 1, 1));
        meas(1, p); meas(2, p); chk("R4 M=256 two periods", p, 24);
        wr(1, 32'(128) << 23);
        wr(0, mk(0, 1, 1, 1, 1));
        meas(1, p); meas(4, p); chk("R4 M=128 four periods", p, 40);

        cur_req = "R9";
        wr(0, mk(0, 0, 0, 1, 1));
        highs = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); highs += ref_out; end
        chk("R9 oe low keeps output low", highs, 0);
        wr(0, mk(0, 0, 0, 0, 1));
        idle(2);
        chk("R9 off output low", {31'b0, ref_out}, 0);

        cur_req = "R5";
        wr(0, mk(3, 1, 1, 1, 0));
        idle(30);
        meas(1, p); chk("R5 bypass follows candidate 3", p, 10);

        cur_req = "R10";
        wr(0, mk(0, 0, 0, 0, 0));
        wr(1, 0);
        wr(0, mk(3, 1, 1, 1, 1));
        meas(1, p); meas(1, p); chk("R10 counts candidate 3 edges", p, 20);
        rd(0, d); chk("R10 select taken when idle", {28'b0, d[3:0]}, 3);

        cur_req = "R7";
        wr(0, mk(3, 0, 0, 0, 1));
        wr(0, mk(3, 1, 0, 0, 2));
        idle(2);
        rd(0, d); chk("R7 idle switch clears", d, 32'h0002_0003);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule